// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit memory-mapped host port and a local set of registers that are wider than the port. Its 128-bit control registers and 64-bit table entries are written piece by piece, one dword at a time. Each piece goes into a staging buffer, and the stored register changes in a single update only when the final dword of the register is written. This way a partly written value can never be seen or used.

Reads work the other way round. Reading the lowest dword of a wide register or table entry returns that dword live. In the same cycle, the whole register is copied into a shadow buffer. The dwords that follow are then served from the shadow, so the host reassembles one consistent value even if the register is updated between its reads.

Each page holds three pointer-style dword registers: an event-queue read pointer and two descriptor-update doorbells. They are written and read directly, with no collection. They may be accessed in the middle of a wide collection without disturbing it.

Top module: `wide_reg_collector`

## Requirements
- R1: After synchronous reset, every stored register, the staging buffers, both shadow buffers and the table arm flag are zero, and `rd_valid` is low.
- R2: The 128-bit register `i` sits at byte address `16*i`, with dword `k` at `16*i + 4*k` in page 0. A write to dword 0, 1 or 2 only loads staging slot `k`, and the stored register keeps its value.
- R3: A write to dword 3 replaces register `i` in one update with `{wr_data, stage2, stage1, stage0}`, where dword `k` occupies bits `32k+31:32k`. The staging slots are shared by all wide registers and are not cleared by a commit, so a commit uses whatever was last staged.
- R4: A read of dword 0 returns live bits 31:0 and copies all 128 bits into the shadow. A read of dword 1, 2 or 3 returns shadow bits `32k+31:32k`, even after the register has since been rewritten.
- R5: Table entry `j` occupies page-0 bytes `0x1000 + 8*j` (low dword) and `+4` (high dword). Writing the low dword stages it and arms the entry commit. Writing the high dword while armed stores `{wr_data, staged_low}` into entry `j` and disarms. Writing the high dword while unarmed changes nothing.
- R6: A read of a table low dword returns live bits 31:0 and snapshots bits 63:32. A read of a high dword returns that snapshot.
- R7: In page `p` (address `p*0x2000 + offset`), the event-queue pointer is at offset 0x1800 and the receive and transmit doorbells are at 0x1810 and 0x1820. A write to any of them takes effect at once and is visible to the next read. Reads return live contents.
- R8: Neither a doorbell or pointer write nor any read changes the wide staging slots. Writes never change the wide shadow. A wide collection interleaved with such accesses commits the dwords written for it.
- R9: `rd_valid` is high in exactly the cycle after each `rd_en`. The following addresses return zero on a read and ignore writes: misaligned addresses, page-0 addresses outside the three regions, and pages above 0 at any offset other than the three dword registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 15 | Byte address shared by reads and writes (13 + page-index bits) |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 32 | Write dword |
| rd_en | input | 1 | One-cycle read strobe |
| rd_valid | output | 1 | Read response strobe, one cycle after `rd_en` |
| rd_data | output | 32 | Read response dword |

## Verification
The checker assumes two things about the inputs: reset is applied before any access, and `addr`, `wr_en` and `rd_en` are stable around each rising edge. The commit and doorbell properties also rely on the decoder never producing an index beyond the arrays. This holds because region bounds come from the same parameters. The stimulus changes inputs only on the falling edge and issues one access per cycle, never both strobes at once. It reaches every region boundary and several illegal addresses, so the one-cycle-later properties see every kind of access.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    localparam int DATA_W     = 32;
    localparam int PAGE_OFS_W = 13;               // 0x2000-byte pages
    localparam int IDX_W      = 8;                // index field width in decode
    localparam int PG_W       = 8;                // page field width in decode
    localparam int N_DREG     = 3;                // dword registers per page

    localparam logic [PAGE_OFS_W-1:0] TBL_OFS = 13'h1000;
    localparam logic [PAGE_OFS_W-1:0] EVQ_OFS = 13'h1800;
    localparam logic [PAGE_OFS_W-1:0] RXD_OFS = 13'h1810;
    localparam logic [PAGE_OFS_W-1:0] TXD_OFS = 13'h1820;

    typedef logic [127:0]                  wide_t;
    typedef logic [63:0]                   entry_t;
    typedef logic [2:0][DATA_W-1:0]        stage_t;
    typedef logic [N_DREG-1:0][DATA_W-1:0] dreg_set_t;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_WIDE  = 2'd1,
        TGT_TABLE = 2'd2,
        TGT_DWORD = 2'd3
    } target_e;

    typedef enum logic [1:0] {
        DREG_EVQ  = 2'd0,
        DREG_RXD  = 2'd1,
        DREG_TXD  = 2'd2,
        DREG_NONE = 2'd3
    } dreg_e;

    typedef struct packed {
        target_e          tgt;
        logic [IDX_W-1:0] idx;
        logic [1:0]       dw;
        logic [PG_W-1:0]  page;
        dreg_e            dsel;
    } decode_t;

    function automatic wide_t merge_wide(input stage_t stg, input logic [DATA_W-1:0] last);
        return {last, stg[2], stg[1], stg[0]};
    endfunction

    function automatic logic [DATA_W-1:0] pick_dword(input wide_t v, input logic [1:0] k);
        return v[32*k +: 32];
    endfunction
endpackage

// File: rtl/wrc_decode.sv
module wrc_decode
    import wrc_pkg::*;
#(
    parameter int N_WIDE  = 8,
    parameter int N_ENTRY = 16,
    parameter int N_PAGE  = 4,
    parameter int ADDR_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    localparam int HI_W = ADDR_W - PAGE_OFS_W;

    logic [PAGE_OFS_W-1:0] off;
    logic [PAGE_OFS_W-1:0] tofs;
    logic [HI_W-1:0]       pg;
    logic                  aligned;
    logic                  page0;
    logic                  page_ok;

    always_comb begin
        off     = addr[PAGE_OFS_W-1:0];
        pg      = addr[ADDR_W-1:PAGE_OFS_W];
        tofs    = off - TBL_OFS;
        aligned = (off[1:0] == 2'b00);
        page0   = (pg == '0);
        page_ok = (32'(pg) < N_PAGE);

        dec      = '0;
        dec.tgt  = TGT_NONE;
        dec.dsel = DREG_NONE;
        dec.page = PG_W'(pg);

        if (aligned) begin
            if (page0 && (32'(off) < N_WIDE * 16)) begin
                dec.tgt = TGT_WIDE;
                dec.idx = IDX_W'(off >> 4);
                dec.dw  = off[3:2];
            end else if (page0 && (off >= TBL_OFS) && (32'(tofs) < N_ENTRY * 8)) begin
                dec.tgt = TGT_TABLE;
                dec.idx = IDX_W'(tofs >> 3);
                dec.dw  = {1'b0, tofs[2]};
            end else if (page_ok && off == EVQ_OFS) begin
                dec.tgt  = TGT_DWORD;
                dec.dsel = DREG_EVQ;
            end else if (page_ok && off == RXD_OFS) begin
                dec.tgt  = TGT_DWORD;
                dec.dsel = DREG_RXD;
            end else if (page_ok && off == TXD_OFS) begin
                dec.tgt  = TGT_DWORD;
                dec.dsel = DREG_TXD;
            end
        end
    end
endmodule

// File: rtl/wrc_wide_bank.sv
module wrc_wide_bank
    import wrc_pkg::*;
#(
    parameter int N_WIDE = 8,
    localparam int IX_W  = (N_WIDE > 1) ? $clog2(N_WIDE) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_hit,
    input  logic [IX_W-1:0]         wr_idx,
    input  logic [1:0]              wr_dw,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    snap_hit,
    input  logic [IX_W-1:0]         snap_idx,
    output wide_t [N_WIDE-1:0]      regs_q,
    output stage_t                  stage_q,
    output wide_t                   shadow_q
);
    localparam logic [1:0] LAST_DW = 2'd3;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q   <= '0;
            stage_q  <= '0;
            shadow_q <= '0;
        end else begin
            if (wr_hit) begin
                if (wr_dw == LAST_DW) begin
                    regs_q[wr_idx] <= merge_wide(stage_q, wr_data);
                end else begin
                    stage_q[wr_dw] <= wr_data;
                end
            end
            if (snap_hit) begin
                shadow_q <= regs_q[snap_idx];
            end
        end
    end
endmodule

// File: rtl/wrc_table_bank.sv
module wrc_table_bank
    import wrc_pkg::*;
#(
    parameter int N_ENTRY = 16,
    localparam int IX_W   = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_hit,
    input  logic [IX_W-1:0]         wr_idx,
    input  logic                    wr_upper,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    snap_hit,
    input  logic [IX_W-1:0]         snap_idx,
    output entry_t [N_ENTRY-1:0]    regs_q,
    output logic [DATA_W-1:0]       lo_q,
    output logic                    armed_q,
    output logic [DATA_W-1:0]       hi_shadow_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q      <= '0;
            lo_q        <= '0;
            armed_q     <= 1'b0;
            hi_shadow_q <= '0;
        end else begin
            if (wr_hit && !wr_upper) begin
                lo_q    <= wr_data;
                armed_q <= 1'b1;
            end else if (wr_hit && armed_q) begin
                regs_q[wr_idx] <= {wr_data, lo_q};
                armed_q        <= 1'b0;
            end
            if (snap_hit) begin
                hi_shadow_q <= regs_q[snap_idx][63:32];
            end
        end
    end
endmodule

// File: rtl/wrc_dword_bank.sv
module wrc_dword_bank
    import wrc_pkg::*;
#(
    parameter int N_PAGE = 4,
    localparam int PIX_W = (N_PAGE > 1) ? $clog2(N_PAGE) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_hit,
    input  logic [PIX_W-1:0]          wr_page,
    input  logic [1:0]                wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    output dreg_set_t [N_PAGE-1:0]    regs_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_hit) begin
            regs_q[wr_page][wr_sel] <= wr_data;
        end
    end
endmodule

// File: rtl/wide_reg_collector.sv
module wide_reg_collector
    import wrc_pkg::*;
#(
    parameter int N_WIDE   = 8,
    parameter int N_ENTRY  = 16,
    parameter int N_PAGE   = 4,
    localparam int WIX_W   = (N_WIDE > 1) ? $clog2(N_WIDE) : 1,
    localparam int TIX_W   = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
    localparam int PIX_W   = (N_PAGE > 1) ? $clog2(N_PAGE) : 1,
    localparam int ADDR_W  = PAGE_OFS_W + PIX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);
    decode_t                adec;
    wide_t [N_WIDE-1:0]     wide_regs;
    stage_t                 wide_stage;
    wide_t                  wide_shd;
    entry_t [N_ENTRY-1:0]   tbl_regs;
    logic [DATA_W-1:0]      tbl_lo;
    logic                   tbl_armed;
    logic [DATA_W-1:0]      tbl_hi_shd;
    dreg_set_t [N_PAGE-1:0] dw_regs;

    logic [WIX_W-1:0] widx;
    logic [TIX_W-1:0] tidx;
    logic [PIX_W-1:0] pidx;
    logic             hit_wide, hit_tbl, hit_dw;
    logic [31:0]      rd_next;

    wrc_decode #(
        .N_WIDE (N_WIDE),
        .N_ENTRY(N_ENTRY),
        .N_PAGE (N_PAGE),
        .ADDR_W (ADDR_W)
    ) i_dec (
        .addr(addr),
        .dec (adec)
    );

    always_comb begin
        widx     = adec.idx[WIX_W-1:0];
        tidx     = adec.idx[TIX_W-1:0];
        pidx     = adec.page[PIX_W-1:0];
        hit_wide = (adec.tgt == TGT_WIDE);
        hit_tbl  = (adec.tgt == TGT_TABLE);
        hit_dw   = (adec.tgt == TGT_DWORD);
    end

    wrc_wide_bank #(.N_WIDE(N_WIDE)) i_wide (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_en && hit_wide),
        .wr_idx  (widx),
        .wr_dw   (adec.dw),
        .wr_data (wr_data),
        .snap_hit(rd_en && hit_wide && adec.dw == 2'd0),
        .snap_idx(widx),
        .regs_q  (wide_regs),
        .stage_q (wide_stage),
        .shadow_q(wide_shd)
    );

    wrc_table_bank #(.N_ENTRY(N_ENTRY)) i_tbl (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_en && hit_tbl),
        .wr_idx     (tidx),
        .wr_upper   (adec.dw[0]),
        .wr_data    (wr_data),
        .snap_hit   (rd_en && hit_tbl && !adec.dw[0]),
        .snap_idx   (tidx),
        .regs_q     (tbl_regs),
        .lo_q       (tbl_lo),
        .armed_q    (tbl_armed),
        .hi_shadow_q(tbl_hi_shd)
    );

    wrc_dword_bank #(.N_PAGE(N_PAGE)) i_dw (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_en && hit_dw),
        .wr_page(pidx),
        .wr_sel (adec.dsel),
        .wr_data(wr_data),
        .regs_q (dw_regs)
    );

    always_comb begin
        rd_next = '0;
        unique case (adec.tgt)
            TGT_WIDE:  rd_next = (adec.dw == 2'd0) ? wide_regs[widx][31:0]
                                                   : pick_dword(wide_shd, adec.dw);
            TGT_TABLE: rd_next = adec.dw[0] ? tbl_hi_shd : tbl_regs[tidx][31:0];
            TGT_DWORD: rd_next = dw_regs[pidx][adec.dsel];
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_next : '0;
        end
    end
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker
    import wrc_pkg::*;
#(
    parameter int N_WIDE  = 8,
    parameter int N_ENTRY = 16,
    parameter int N_PAGE  = 4,
    localparam int WIX_W  = (N_WIDE > 1) ? $clog2(N_WIDE) : 1,
    localparam int PIX_W  = (N_PAGE > 1) ? $clog2(N_PAGE) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic                   rd_valid,
    input logic [31:0]            wr_data,
    input decode_t                adec,
    input wide_t [N_WIDE-1:0]     wide_regs,
    input stage_t                 wide_stage,
    input wide_t                  wide_shd,
    input entry_t [N_ENTRY-1:0]   tbl_regs,
    input logic                   tbl_armed,
    input dreg_set_t [N_PAGE-1:0] dw_regs
);
    // R9: a response follows every read strobe, and only a read strobe
    assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);
    assert_rsp_caused_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

    // R2: partial wide writes leave every stored register untouched
    assert_stage_only_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adec.tgt == TGT_WIDE && adec.dw != 2'd3) |=> $stable(wide_regs));

    // R3: last-dword write installs staged dwords plus the write data
    assert_commit_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adec.tgt == TGT_WIDE && adec.dw == 2'd3) |=>
        (wide_regs[$past(adec.idx[WIX_W-1:0])] == {$past(wr_data), $past(wide_stage)}));

    // R5: high-dword write without a staged low dword changes no entry
    assert_unarmed_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adec.tgt == TGT_TABLE && adec.dw[0] && !tbl_armed) |=> $stable(tbl_regs));

    // R7: dword register writes land at once
    assert_dword_now_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adec.tgt == TGT_DWORD) |=>
        (dw_regs[$past(adec.page[PIX_W-1:0])][2'($past(adec.dsel))] == $past(wr_data)));

    // R8: dword writes and reads keep the staging; writes keep the shadow
    assert_dword_keeps_stage_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && adec.tgt == TGT_DWORD) |=> $stable(wide_stage));
    assert_read_keeps_stage_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> $stable(wide_stage));
    assert_write_keeps_shadow_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |=> $stable(wide_shd));
endmodule

bind wide_reg_collector wrc_checker #(
    .N_WIDE (N_WIDE),
    .N_ENTRY(N_ENTRY),
    .N_PAGE (N_PAGE)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .wr_data   (wr_data),
    .adec      (adec),
    .wide_regs (wide_regs),
    .wide_stage(wide_stage),
    .wide_shd  (wide_shd),
    .tbl_regs  (tbl_regs),
    .tbl_armed (tbl_armed),
    .dw_regs   (dw_regs)
);

// File: tb/test_wide_reg_collector.sv
module test_wide_reg_collector;
    localparam int NW = 8;
    localparam int NE = 16;
    localparam int NP = 4;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_valid;
    logic [31:0]   rd_data;

    wide_reg_collector #(.N_WIDE(NW), .N_ENTRY(NE), .N_PAGE(NP)) i_wide_reg_collector (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit [127:0] m_wide [NW];
    bit [31:0]  m_stg  [3];
    bit [127:0] m_shd;
    bit [63:0]  m_tbl  [NE];
    bit [31:0]  m_tlo;
    bit         m_arm;
    bit [31:0]  m_tshd;
    bit [31:0]  m_dr   [NP][3];
    bit         exp_vld;

    task automatic model(input int a, input bit is_wr, input bit [31:0] d, output bit [31:0] r);
        int pg;
        int off;
        pg  = a / 8192;
        off = a % 8192;
        r   = 0;
        if (off % 4 != 0) return;
        if (pg == 0 && off < NW * 16) begin
            int i;
            int k;
            i = off / 16;
            k = (off % 16) / 4;
            if (is_wr) begin
                if (k == 3) m_wide[i] = {d, m_stg[2], m_stg[1], m_stg[0]};
                else        m_stg[k] = d;
            end else if (k == 0) begin
                r = m_wide[i][31:0];
                m_shd = m_wide[i];
            end else begin
                r = m_shd[k*32 +: 32];
            end
        end else if (pg == 0 && off >= 'h1000 && off < 'h1000 + NE * 8) begin
            int j;
            int hi;
            j  = (off - 'h1000) / 8;
            hi = ((off - 'h1000) % 8) / 4;
            if (is_wr) begin
                if (hi == 0) begin
                    m_tlo = d;
                    m_arm = 1'b1;
                end else if (m_arm) begin
                    m_tbl[j] = {d, m_tlo};
                    m_arm = 1'b0;
                end
            end else if (hi == 0) begin
                r = m_tbl[j][31:0];
                m_tshd = m_tbl[j][63:32];
            end else begin
                r = m_tshd;
            end
        end else if (pg < NP && (off == 'h1800 || off == 'h1810 || off == 'h1820)) begin
            int s;
            s = (off - 'h1800) / 16;
            if (is_wr) m_dr[pg][s] = d;
            else       r = m_dr[pg][s];
        end
    endtask

    task automatic wr(input int a, input bit [31:0] d);
        bit [31:0] unused_r;
        model(a, 1'b1, d, unused_r);
        addr    = AW'(a);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        bit [31:0] e;
        model(a, 1'b0, 32'h0, e);
        addr  = AW'(a);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        checks++;
        if (rd_data !== e) begin
            failures++;
            $display("FAIL %s addr=%h act=%h exp=%h", tag, a, rd_data, e);
        end
    endtask

    // response strobe compared every clock (R9, R1 during reset)
    always @(posedge clk) exp_vld <= rst ? 1'b0 : rd_en;
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rd_valid !== exp_vld) begin
                failures++;
                $display("FAIL R9 rd_valid act=%b exp=%b", rd_valid, exp_vld);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog act=20000 cycles exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset contents
        rd('h0000, "R1");
        rd('h001C, "R1");
        rd('h1000, "R1");
        rd('h1004, "R1");
        rd('h7810, "R1");

        // R2: partial writes stage only
        wr('h0020, 32'hA000_0000);
        wr('h0024, 32'hA111_1111);
        wr('h0028, 32'hA222_2222);
        rd('h0020, "R2");
        rd('h002C, "R2");

        // R3: commit on last dword
        wr('h002C, 32'hA333_3333);
        rd('h0020, "R3");
        rd('h0024, "R3");
        rd('h0028, "R3");
        rd('h002C, "R3");

        // R4: shadow holds snapshot across a rewrite
        rd('h0020, "R4");
        wr('h0020, 32'hB000_0000);
        wr('h0024, 32'hB111_1111);
        wr('h0028, 32'hB222_2222);
        wr('h002C, 32'hB333_3333);
        rd('h0024, "R4");
        rd('h0028, "R4");
        rd('h002C, "R4");
        rd('h0020, "R4");
        rd('h0028, "R4");

        // R8: dword writes and a read in the middle of a collection
        wr('h0050, 32'hC000_0000);
        wr('h0054, 32'hC111_1111);
        wr('h3800, 32'hD000_0001);
        rd('h0010, "R8");
        wr('h0058, 32'hC222_2222);
        wr('h7810, 32'hD000_0002);
        wr('h005C, 32'hC333_3333);
        rd('h0050, "R8");
        rd('h0054, "R8");
        rd('h0058, "R8");
        rd('h005C, "R8");

        // R7: designated dword registers, paged
        rd('h3800, "R7");
        rd('h7810, "R7");
        wr('h1820, 32'hD000_0003);
        rd('h1820, "R7");
        rd('h5800, "R7");
        rd('h7820, "R7");

        // R3: commit with stale staging into another register, last index
        wr('h000C, 32'hE333_3333);
        rd('h0000, "R3");
        rd('h0004, "R3");
        rd('h0008, "R3");
        rd('h000C, "R3");
        wr('h0070, 32'h7000_0000);
        wr('h0074, 32'h7111_1111);
        wr('h0078, 32'h7222_2222);
        wr('h007C, 32'h7333_3333);
        rd('h0070, "R3");
        rd('h007C, "R3");

        // R5: table entries
        wr('h1018, 32'hF000_0000);
        wr('h101C, 32'hF111_1111);
        rd('h1018, "R5");
        rd('h101C, "R5");
        wr('h1024, 32'h9999_9999);
        rd('h1020, "R5");
        rd('h1024, "R5");
        wr('h1078, 32'h1515_0000);
        wr('h107C, 32'h1515_1111);
        rd('h1078, "R5");
        rd('h107C, "R5");

        // R6: table snapshot on low read
        rd('h1018, "R6");
        wr('h1018, 32'h8800_0000);
        wr('h101C, 32'h8811_1111);
        rd('h101C, "R6");
        rd('h1018, "R6");
        rd('h101C, "R6");

        // R9: unmapped and misaligned accesses
        wr('h2000, 32'h5555_0000);
        wr('h200C, 32'h5555_3333);
        wr('h0022, 32'h5555_2222);
        wr('h0080, 32'h5555_8888);
        wr('h1804, 32'h5555_1804);
        wr('h1080, 32'h5555_1080);
        rd('h0000, "R9");
        rd('h2000, "R9");
        rd('h0080, "R9");
        rd('h1804, "R9");
        rd('h1080, "R9");
        rd('h0022, "R9");
        wr('h003C, 32'h3C3C_3C3C);
        rd('h0030, "R9");
        rd('h0034, "R9");
        rd('h0038, "R9");
        rd('h003C, "R9");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule